// File: doc/BRIEF.md
# HDLC Receive Packet Controller

This block takes a serial line bit stream, qualified by a per-bit enable, and turns it into packets stored byte by byte in an on-chip receive queue. Before any other processing it can invert every incoming bit. It then hunts for the opening flag (`0x7E`) and deletes the zero that follows five ones inside a frame. It ends a frame on a closing flag, and on seven consecutive ones it aborts the frame. It collects bits into bytes and can check a trailing 16-bit frame check sequence (FCS).

Each queue entry holds one data byte, an end-of-packet tag and a two-bit packet status. A packed 16-bit control word selects the following at run time:
- the data-available threshold, in units of eight bytes;
- the bit order within each stored byte;
- line inversion;
- whether frames carry an FCS.

The control word can also hold the queue in reset. Software reads the queue through a show-ahead read port. It sees a threshold flag, three latched event bits that it clears by writing ones, and an interrupt that is masked per event.

Top module: `hdlc_rx_ctrl`

## Requirements
- R1: When `ctrl[2]` is 1, every line bit is inverted before flag detection and all later processing. When it is 0, line bits are used as received.
- R2: A frame opens after a `0x7E` flag and closes at the next flag, and one flag may close one frame and open the next. Inside a frame, a 0 that follows five consecutive 1s is deleted from the data.
- R3: When `ctrl[3]` is 0, the first received bit of each byte is stored in `rd_data[0]`. When `ctrl[3]` is 1, it is stored in `rd_data[7]`.
- R4: When `ctrl[1]` is 0, the last two bytes of a frame are taken as an FCS. The FCS is CRC-16 with polynomial x^16+x^12+x^5+1, bit-reflected, with a start value of 0xFFFF. The frame is good when the remainder over the data bytes plus the FCS equals 0xF0B8. The two FCS bytes are never stored.
- R5: When `ctrl[1]` is 1, no FCS is assumed. Every byte of the frame is stored and the status is good.
- R6: Each stored byte carries `rd_eop`, which is 1 only on the last stored byte of a packet. It also carries `rd_stat`, which is meaningful on that last byte: 0 good, 1 FCS error, 2 abort, 3 overflow. `rd_valid` is 1 while the queue is not empty, `rd_data`/`rd_eop`/`rd_stat` show the oldest entry, and `rd_en` removes that entry.
- R7: Seven consecutive 1s inside a frame abort it. The bytes already stored for that frame are closed with `rd_eop`=1 and status 2, and the block hunts for the next flag.
- R8: A frame with fewer than two data bytes, counted after any FCS is removed, leaves nothing in the queue.
- R9: `data_avail` is 1 when the queue holds at least `ctrl[12:8]`×8 bytes. A level of 0 acts as a threshold of one byte.
- R10: The queue holds 256 entries. A byte that arrives while it is full is dropped, and `stat_latch[1]` is set.
- R11: `stat_latch[0]` is set on the rising edge of `data_avail`, `stat_latch[1]` on a dropped byte, and `stat_latch[2]` on each stored end-of-packet byte. A 1 on a bit of `stat_clr` clears that latched bit. A set and a clear of the same bit in the same cycle leave it set.
- R12: `irq` is 1 exactly when some latched bit is 1 and its bit in `stat_ien` is 1.
- R13: While `ctrl[0]` is 1, the queue is empty and any frame in progress is dropped. Receiving resumes at the first flag after `ctrl[0]` returns to 0.
- R14: After reset, `rd_valid`, `data_avail`, `stat_latch` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 16 | Control word: level [12:8], bit order [3], invert [2], FCS off [1], queue reset [0] |
| bit_in | input | 1 | Serial line bit |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| rd_en | input | 1 | Pops the oldest queue entry |
| rd_data | output | 8 | Data byte of the oldest entry |
| rd_eop | output | 1 | End-of-packet tag of the oldest entry |
| rd_stat | output | 2 | Packet status of the oldest entry |
| rd_valid | output | 1 | Queue not empty |
| data_avail | output | 1 | Fill level at or above the threshold |
| stat_clr | input | 3 | Write-one-to-clear for the latched bits |
| stat_ien | input | 3 | Interrupt enable per latched bit |
| stat_latch | output | 3 | Latched events: [0] data available, [1] overflow, [2] packet end |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can act on the packet-end latch in the same clock: a new end-of-packet write sets it while a software clear removes it. The bench holds the packet-end clear bit high for the whole of a frame, so the set edge is sure to land on a cycle that also carries a clear. It then judges by a monitor that must see the latched bit high for at least one cycle, and by the bit being low again once the frame has been processed.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    typedef enum logic [1:0] {
        ST_GOOD   = 2'd0,
        ST_FCSERR = 2'd1,
        ST_ABORT  = 2'd2,
        ST_OVFL   = 2'd3
    } pkt_stat_e;

    typedef struct packed {
        logic      eop;
        pkt_stat_e stat;
        logic [7:0] data;
    } fifo_entry_t;

    typedef struct packed {
        logic [4:0] level;
        logic       reorder;
        logic       invert;
        logic       fcs_off;
        logic       fifo_rst;
    } rx_cfg_t;

    localparam logic [15:0] CRC_INIT = 16'hFFFF;
    localparam logic [15:0] CRC_GOOD = 16'hF0B8;
    localparam logic [15:0] CRC_POLY = 16'h8408;

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            r = (r[0] ^ b[i]) ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic rx_cfg_t decode_cfg(input logic [15:0] w);
        rx_cfg_t c;
        c.level    = w[12:8];
        c.reorder  = w[3];
        c.invert   = w[2];
        c.fcs_off  = w[1];
        c.fifo_rst = w[0];
        return c;
    endfunction

endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  rx_cfg_t     cfg,
    input  logic        bit_in,
    input  logic        bit_en,
    input  logic        drop,
    output logic        wr_en,
    output fifo_entry_t wr_entry
);
    logic        in_frame, pkt_ovf;
    logic [2:0]  ones, bitcnt, tot;
    logic [7:0]  sr;
    logic [7:0]  hold [3];
    logic [15:0] crc;

    logic        lb, is_stuff, is_flag, is_abort, is_data, byte_done, has_written;
    logic [2:0]  depth;
    logic [7:0]  new_byte, oldest, out_byte;
    pkt_stat_e   close_stat;

    always_comb begin
        lb          = bit_in ^ cfg.invert;
        is_flag     = bit_en && !lb && (ones == 3'd6);
        is_abort    = bit_en && lb && (ones == 3'd6);
        is_stuff    = bit_en && !lb && (ones == 3'd5);
        is_data     = bit_en && in_frame && !is_flag && !is_abort && !is_stuff && (ones != 3'd7);
        new_byte    = {lb, sr[7:1]};
        byte_done   = is_data && (bitcnt == 3'd7);
        depth       = cfg.fcs_off ? 3'd1 : 3'd3;
        oldest      = cfg.fcs_off ? hold[0] : hold[2];
        out_byte    = cfg.reorder ? rev8(oldest) : oldest;
        has_written = in_frame && (tot > depth);
        if (is_abort || bitcnt != 3'd7)           close_stat = ST_ABORT;
        else if (pkt_ovf)                         close_stat = ST_OVFL;
        else if (!cfg.fcs_off && crc != CRC_GOOD) close_stat = ST_FCSERR;
        else                                      close_stat = ST_GOOD;
    end

    always_ff @(posedge clk) begin
        if (rst || cfg.fifo_rst) begin
            in_frame <= 1'b0;
            pkt_ovf  <= 1'b0;
            ones     <= 3'd0;
            bitcnt   <= 3'd0;
            tot      <= 3'd0;
            sr       <= 8'd0;
            crc      <= CRC_INIT;
            hold[0]  <= 8'd0;
            hold[1]  <= 8'd0;
            hold[2]  <= 8'd0;
            wr_en    <= 1'b0;
            wr_entry <= '0;
        end else begin
            wr_en <= 1'b0;
            if (drop) pkt_ovf <= 1'b1;
            if (bit_en) ones <= lb ? ((ones == 3'd7) ? 3'd7 : ones + 3'd1) : 3'd0;
            if (is_flag) begin
                in_frame <= 1'b1;
                tot      <= 3'd0;
                bitcnt   <= 3'd0;
                crc      <= CRC_INIT;
                pkt_ovf  <= 1'b0;
                if (has_written) begin
                    wr_en    <= 1'b1;
                    wr_entry <= fifo_entry_t'{eop: 1'b1, stat: close_stat, data: out_byte};
                end
            end else if (is_abort) begin
                in_frame <= 1'b0;
                if (has_written) begin
                    wr_en    <= 1'b1;
                    wr_entry <= fifo_entry_t'{eop: 1'b1, stat: ST_ABORT, data: out_byte};
                end
            end else if (is_data) begin
                sr     <= new_byte;
                bitcnt <= bitcnt + 3'd1;
                if (byte_done) begin
                    crc     <= crc_byte(crc, new_byte);
                    hold[2] <= hold[1];
                    hold[1] <= hold[0];
                    hold[0] <= new_byte;
                    tot     <= (tot == 3'd7) ? 3'd7 : tot + 3'd1;
                    if (tot >= depth) begin
                        wr_en    <= 1'b1;
                        wr_entry <= fifo_entry_t'{eop: 1'b0, stat: ST_GOOD, data: out_byte};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  fifo_entry_t   wr_entry,
    input  logic          rd_en,
    output fifo_entry_t   rd_entry,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          drop
);
    fifo_entry_t   mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_wr, do_rd;

    always_comb begin
        full     = (count == CW'(DEPTH));
        do_wr    = wr_en && !full;
        do_rd    = rd_en && (count != '0);
        drop     = wr_en && full;
        rd_entry = mem[rptr];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + CW'(do_wr) - CW'(do_rd);
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_entry;
    end
endmodule

// File: rtl/hdlc_rx_status.sv
module hdlc_rx_status #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ien,
    output logic [N-1:0] latch,
    output logic         irq
);
    logic [N-1:0] ev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q  <= '0;
            latch <= '0;
        end else begin
            ev_q <= ev;
            for (int i = 0; i < N; i++) begin
                if (ev[i] && !ev_q[i]) latch[i] <= 1'b1;
                else if (clr[i])       latch[i] <= 1'b0;
            end
        end
    end

    assign irq = |(latch & ien);
endmodule

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int GROUP = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NEV = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [15:0]    ctrl,
    input  logic           bit_in,
    input  logic           bit_en,
    input  logic           rd_en,
    output logic [7:0]     rd_data,
    output logic           rd_eop,
    output logic [1:0]     rd_stat,
    output logic           rd_valid,
    output logic           data_avail,
    input  logic [NEV-1:0] stat_clr,
    input  logic [NEV-1:0] stat_ien,
    output logic [NEV-1:0] stat_latch,
    output logic           irq
);
    rx_cfg_t       cfg;
    fifo_entry_t   wr_entry, rd_entry;
    logic          wr_en, fifo_full, fifo_drop, fifo_clr;
    logic [CW-1:0] count, thresh;
    logic [NEV-1:0] events;

    always_comb begin
        cfg      = decode_cfg(ctrl);
        fifo_clr = cfg.fifo_rst;
        thresh   = (cfg.level == '0) ? CW'(1) : CW'(cfg.level) * CW'(GROUP);
        data_avail = (count >= thresh);
        rd_valid = (count != '0);
        rd_data  = rd_entry.data;
        rd_eop   = rd_entry.eop;
        rd_stat  = rd_entry.stat;
        events   = {wr_en && wr_entry.eop && !fifo_full, fifo_drop, data_avail};
    end

    hdlc_rx_deframer u_deframer (
        .clk(clk), .rst(rst), .cfg(cfg), .bit_in(bit_in), .bit_en(bit_en),
        .drop(fifo_drop), .wr_en(wr_en), .wr_entry(wr_entry)
    );

    hdlc_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .clr(fifo_clr), .wr_en(wr_en), .wr_entry(wr_entry),
        .rd_en(rd_en), .rd_entry(rd_entry), .count(count), .full(fifo_full), .drop(fifo_drop)
    );

    hdlc_rx_status #(.N(NEV)) u_status (
        .clk(clk), .rst(rst), .ev(events), .clr(stat_clr), .ien(stat_ien),
        .latch(stat_latch), .irq(irq)
    );
endmodule

// File: rtl/hdlc_rx_ctrl_chk.sv
module hdlc_rx_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       fifo_clr,
    input logic       fifo_full,
    input logic       rd_en,
    input logic       rd_valid,
    input logic       data_avail,
    input logic [2:0] stat_clr,
    input logic [2:0] stat_ien,
    input logic [2:0] stat_latch,
    input logic       irq
);
    // R9: the threshold flag never claims data in an empty queue
    assert_avail_has_data_R9: assert property (@(posedge clk) disable iff (rst)
        data_avail |-> rd_valid);

    // R13: a queue reset leaves nothing to read
    assert_clear_empties_R13: assert property (@(posedge clk) disable iff (rst)
        $past(fifo_clr) |-> !rd_valid);

    // R11: a latched bit stays set until a clear is written for it
    assert_latch_hold_R11: assert property (@(posedge clk) disable iff (rst)
        ((($past(stat_latch) & ~$past(stat_clr)) & ~stat_latch) == 3'b000));

    // R10: the overflow bit rises only after a write met a full queue
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_latch[1]) |-> $past(fifo_full));

    // R12: no interrupt while every enable is off
    assert_irq_masked_R12: assert property (@(posedge clk) disable iff (rst)
        (stat_ien == 3'b000) |-> !irq);

    // R6: entries leave the queue only by a read or a queue reset
    assert_valid_falls_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_valid) |-> ($past(rd_en) || $past(fifo_clr)));
endmodule

bind hdlc_rx_ctrl hdlc_rx_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .fifo_clr(fifo_clr), .fifo_full(fifo_full),
    .rd_en(rd_en), .rd_valid(rd_valid), .data_avail(data_avail),
    .stat_clr(stat_clr), .stat_ien(stat_ien), .stat_latch(stat_latch), .irq(irq)
);

// File: tb/hdlc_rx_ctrl_bench.sv
`timescale 1ns/1ps
module hdlc_rx_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ctrl = 16'h0;
    logic        bit_in = 1'b0, bit_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_eop, rd_valid, data_avail, irq;
    logic [1:0]  rd_stat;
    logic [2:0]  stat_clr = 3'b0, stat_ien = 3'b0, stat_latch;

    always #10 clk = ~clk;

    hdlc_rx_ctrl u_hdlc_rx_ctrl (
        .clk(clk), .rst(rst), .ctrl(ctrl), .bit_in(bit_in), .bit_en(bit_en),
        .rd_en(rd_en), .rd_data(rd_data), .rd_eop(rd_eop), .rd_stat(rd_stat),
        .rd_valid(rd_valid), .data_avail(data_avail), .stat_clr(stat_clr),
        .stat_ien(stat_ien), .stat_latch(stat_latch), .irq(irq)
    );

    int checks = 0, errors = 0;
    bit line_inv = 0;
    bit reorder  = 0;
    int ones_tx  = 0;
    logic [10:0] expq[$];
    bit mon_on = 0, mon_seen = 0;

    always @(negedge clk) if (mon_on && stat_latch[2]) mon_seen = 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc16(input logic [7:0] d[$]);
        logic [15:0] c = 16'hFFFF;
        foreach (d[k]) for (int i = 0; i < 8; i++)
            c = (c[0] ^ d[k][i]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        return c;
    endfunction

    function automatic logic [7:0] flip(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [15:0] mk_ctrl(input int level, input bit ro, input bit inv,
                                            input bit fcs_off, input bit frst);
        return {3'b0, 5'(level), 4'b0, ro, inv, fcs_off, frst};
    endfunction

    task automatic send_bit(input bit b);
        if ($urandom_range(0, 3) == 0) begin
            @(negedge clk); bit_en = 1'b0;
        end
        @(negedge clk);
        bit_in = b ^ line_inv;
        bit_en = 1'b1;
    endtask

    task automatic send_flag();
        for (int i = 0; i < 8; i++) send_bit((8'h7E >> i) & 1);
        ones_tx = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            send_bit(b[i]);
            ones_tx = b[i] ? ones_tx + 1 : 0;
            if (ones_tx == 5) begin
                send_bit(1'b0);
                ones_tx = 0;
            end
        end
    endtask

    task automatic idle();
        @(negedge clk); bit_en = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d[$], input bit with_fcs, input bit bad);
        logic [15:0] f;
        send_flag();
        foreach (d[k]) send_byte(d[k]);
        if (with_fcs) begin
            f = ~crc16(d);
            if (bad) f = f ^ 16'h0001;
            send_byte(f[7:0]);
            send_byte(f[15:8]);
        end
        send_flag();
        idle();
    endtask

    task automatic expect_frame(input logic [7:0] d[$], input logic [1:0] st);
        if (d.size() < 2) return;
        foreach (d[k]) begin
            logic [7:0] v = reorder ? flip(d[k]) : d[k];
            expq.push_back({(k == d.size() - 1), (k == d.size() - 1) ? st : 2'b00, v});
        end
    endtask

    task automatic rand_bytes(output logic [7:0] d[$], input int n);
        d = {};
        for (int i = 0; i < n; i++) d.push_back(8'($urandom_range(0, 255)));
    endtask

    task automatic drain(input string req);
        logic [10:0] e, got;
        repeat (3) @(negedge clk);
        while (rd_valid) begin
            got = {rd_eop, rd_stat, rd_data};
            if (expq.size() == 0) chk(0, req, "unexpected entry", got, 0);
            else begin
                e = expq.pop_front();
                chk(got == e, req, "entry {eop,stat,data}", got, e);
            end
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        chk(expq.size() == 0, req, "missing entries", expq.size(), 0);
        expq = {};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=0 expected=1");
        checks++; errors++;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d[$];
        logic [7:0] dd[$];
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R14 reset state
        chk(rd_valid == 0, "R14", "rd_valid", rd_valid, 0);
        chk(data_avail == 0, "R14", "data_avail", data_avail, 0);
        chk(stat_latch == 0, "R14", "stat_latch", stat_latch, 0);
        chk(irq == 0, "R14", "irq", irq, 0);

        // R2 R4 R6 good frames with FCS, incl. stuffing-heavy directed data
        ctrl = mk_ctrl(0, 0, 0, 0, 0);
        d = {8'hFF, 8'hFF, 8'h7E, 8'hFC, 8'h3F, 8'h1F};
        send_frame(d, 1, 0); expect_frame(d, 2'd0);
        for (int k = 0; k < 6; k++) begin
            rand_bytes(d, $urandom_range(2, 24));
            send_frame(d, 1, 0); expect_frame(d, 2'd0);
        end
        drain("R2_R4_good");

        // R4 corrupted FCS
        rand_bytes(d, 9); send_frame(d, 1, 1); expect_frame(d, 2'd1);
        rand_bytes(d, 2); send_frame(d, 1, 1); expect_frame(d, 2'd1);
        drain("R4_fcs_error");

        // R5 no FCS
        ctrl = mk_ctrl(0, 0, 0, 1, 0);
        for (int k = 0; k < 4; k++) begin
            rand_bytes(d, $urandom_range(2, 12));
            send_frame(d, 0, 0); expect_frame(d, 2'd0);
        end
        drain("R5_no_fcs");

        // R3 reversed bit order
        reorder = 1; ctrl = mk_ctrl(0, 1, 0, 0, 0);
        for (int k = 0; k < 3; k++) begin
            rand_bytes(d, $urandom_range(2, 10));
            send_frame(d, 1, 0); expect_frame(d, 2'd0);
        end
        drain("R3_reorder");
        reorder = 0;

        // R1 inverted line
        ctrl = mk_ctrl(0, 0, 1, 0, 0);
        line_inv = 1;
        idle();
        for (int k = 0; k < 3; k++) begin
            rand_bytes(d, $urandom_range(2, 10));
            send_frame(d, 1, 0); expect_frame(d, 2'd0);
        end
        drain("R1_invert");
        line_inv = 0;
        ctrl = mk_ctrl(0, 0, 0, 0, 0);
        send_flag(); idle();

        // R7 abort: 6 bytes received with FCS assumed -> first 4 stored
        rand_bytes(d, 6);
        send_flag();
        foreach (d[k]) send_byte(d[k]);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        send_flag(); idle();
        dd = d[0:3]; expect_frame(dd, 2'd2);
        rand_bytes(d, 2);
        send_flag();
        foreach (d[k]) send_byte(d[k]);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        send_flag(); idle();
        drain("R7_abort");

        // R8 short frames
        d = {8'h5A}; send_frame(d, 1, 0);
        ctrl = mk_ctrl(0, 0, 0, 1, 0);
        d = {8'hA5}; send_frame(d, 0, 0);
        d = {8'h11, 8'h22}; send_frame(d, 0, 0); expect_frame(d, 2'd0);
        drain("R8_short");

        // R9 threshold two groups = 16 bytes
        ctrl = mk_ctrl(2, 0, 0, 1, 0);
        rand_bytes(d, 15); send_frame(d, 0, 0); expect_frame(d, 2'd0);
        chk(data_avail == 0, "R9", "data_avail at 15", data_avail, 0);
        rand_bytes(d, 2); send_frame(d, 0, 0); expect_frame(d, 2'd0);
        chk(data_avail == 1, "R9", "data_avail at 17", data_avail, 1);
        chk(stat_latch[0] == 1, "R11", "avail latch", stat_latch[0], 1);
        drain("R9_threshold");
        chk(data_avail == 0, "R9", "data_avail drained", data_avail, 0);

        // R12 R11 interrupt masking and write-one-clear
        stat_ien = 3'b100; @(negedge clk);
        chk(irq == 1, "R12", "irq enabled", irq, 1);
        stat_ien = 3'b010; @(negedge clk);
        chk(irq == 0, "R12", "irq masked", irq, 0);
        stat_clr = 3'b111; @(negedge clk); stat_clr = 3'b000; @(negedge clk);
        chk(stat_latch == 0, "R11", "latch cleared", stat_latch, 0);

        // R10 overflow: 300 bytes into 256 entries
        ctrl = mk_ctrl(0, 0, 0, 1, 0);
        for (int k = 0; k < 3; k++) begin
            rand_bytes(d, 100);
            send_frame(d, 0, 0);
            if (k < 2) expect_frame(d, 2'd0);
            else for (int i = 0; i < 56; i++) expq.push_back({3'b000, d[i]});
        end
        chk(stat_latch[1] == 1, "R10", "overflow latch", stat_latch[1], 1);
        chk(irq == 1, "R12", "irq on overflow", irq, 1);
        drain("R10_overflow");
        stat_clr = 3'b111; @(negedge clk); stat_clr = 3'b000;

        // R11 set and clear in the same cycle
        ctrl = mk_ctrl(0, 0, 0, 0, 0);
        stat_clr = 3'b100; mon_seen = 0; mon_on = 1;
        rand_bytes(d, 5); send_frame(d, 1, 0); expect_frame(d, 2'd0);
        mon_on = 0;
        chk(mon_seen == 1, "R11", "set wins over clear", mon_seen, 1);
        chk(stat_latch[2] == 0, "R11", "later clear", stat_latch[2], 0);
        stat_clr = 3'b000;
        drain("R11_collide");

        // R13 queue reset, mid-frame drop, resume at next flag
        rand_bytes(d, 4); send_frame(d, 1, 0);
        chk(rd_valid == 1, "R13", "filled", rd_valid, 1);
        ctrl = mk_ctrl(0, 0, 0, 0, 1); repeat (2) @(negedge clk);
        chk(rd_valid == 0, "R13", "emptied", rd_valid, 0);
        ctrl = mk_ctrl(0, 0, 0, 0, 0);
        send_flag();
        for (int i = 0; i < 3; i++) send_byte(8'h30 + 8'(i));
        @(negedge clk); bit_en = 1'b0;
        ctrl = mk_ctrl(0, 0, 0, 0, 1); repeat (2) @(negedge clk);
        ctrl = mk_ctrl(0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) send_byte(8'h40 + 8'(i));
        send_flag(); idle();
        rand_bytes(d, 6); send_frame(d, 1, 0); expect_frame(d, 2'd0);
        drain("R13_reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule